// File: doc/BRIEF.md
# Sleep-Directing Fixed-Priority Bus Arbiter

This block decides which of two masters owns a shared peripheral bus. Ownership goes by fixed priority. The arbiter also tells the master that was refused to drop into a low-power wait. Without this, the refused master would spin at full clock rate until the bus came free. The arbiter raises a per-master sleep level for as long as that master is kept off the bus by the other owner. On release it sends a single-cycle wake pulse to a sleeper that it grants the bus to. Software takes no part in putting a master to sleep or waking it.

The owner keeps the bus while its transfer is running (until `done_i`), and for as long as it holds `lock_i`. The grant is re-evaluated only when the bus is idle: no owner, or the owner is unlocked and its transfer has finished. Each master is seen as a request/acknowledge agent. Bit i of every per-master vector belongs to master i, and master 0 has the highest priority.

Top module: `bus_sleep_arbiter`

## Requirements
- R1: While `rst_ni` is low, `gnt_o`, `sleep_o` and `wake_o` are all zero, and they go to zero asynchronously when reset is asserted.
- R2: When the bus is idle, the clock edge grants the lowest-index requesting master. `gnt_o` is one-hot or zero, and a new grant bit is set only for a master that was requesting before that edge.
- R3: While the owner holds `lock_i` high, `gnt_o` does not change, even if `done_i` has already been seen. Once `done_i` has been seen, dropping `lock_i` frees the bus.
- R4: Without a lock, the owner keeps `gnt_o` until a cycle in which `done_i` is high. The bus is released at that edge.
- R5: A requesting master that does not own the bus while the other master does gets `sleep_o` high from the edge at which it was refused. `sleep_o[i]` is never high unless master i requests and another master owns the bus.
- R6: If a sleeping master drops its request, its `sleep_o` bit falls in the same cycle, before the next clock edge.
- R7: When a sleeping master is granted at a release, `wake_o` for that master is high in exactly the first cycle in which its `gnt_o` bit is high.
- R8: A `wake_o` bit is never high for two cycles in a row.
- R9: A release with no request pending leaves `gnt_o` at zero. `done_i` and `lock_i` have no effect while nothing is granted.
- R10: If the owner is master 0 and it is still requesting at a release, it keeps the bus. The waiting master stays asleep and gets no wake pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MST | Bus request, one bit per master |
| lock_i | input | 1 | Lock from the current owner; holds the grant |
| done_i | input | 1 | Transfer of the current owner has finished |
| gnt_o | output | N_MST | One-hot bus grant |
| sleep_o | output | N_MST | Low-power wait request to a refused master |
| wake_o | output | N_MST | Single-cycle wake pulse on grant to a sleeper |

## Verification
The bench targets several corner cases:
- `done_i` arriving while `lock_i` is still high. A design that forgot the completed transfer would keep the bus after the lock dropped. A design that ignored the lock would hand the bus over early.
- The owner re-requesting at a release while the other master sleeps. A design that woke every sleeper on release would send a spurious wake pulse there.
- A sleeper withdrawing its request. A registered-only sleep would hold `sleep_o` high for one extra cycle, and a wake path that did not check the request would still fire later.
- `done_i` with no owner, a release with no requesters, and an asynchronous reset in the middle of an ownership. Each of these would expose a stale grant.

// File: rtl/bus_sleep_arb_pkg.sv
package bus_sleep_arb_pkg;

  // ownership phase of the bus
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,  // no owner
    OWN_XFER  = 2'd1,  // owner, transfer running
    OWN_DRAIN = 2'd2   // owner, transfer done, waiting for lock release
  } own_phase_e;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N_MST = 2
) (
  input  logic [N_MST-1:0] req_i,
  output logic [N_MST-1:0] pick_o
);

  logic [N_MST-1:0] above;

  assign above[0]  = 1'b0;
  assign pick_o[0] = req_i[0];

  for (genvar i = 1; i < N_MST; i++) begin : g_chain
    assign above[i]  = above[i-1] | req_i[i-1];
    assign pick_o[i] = req_i[i] & ~above[i];
  end

endmodule

// File: rtl/arb_hold_ctrl.sv
module arb_hold_ctrl
  import bus_sleep_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic done_i,
  input  logic regrant_i,
  output logic free_o
);

  own_phase_e phase_q, phase_d;

  // bus is free with no owner, or owner unlocked and transfer finished
  assign free_o = (phase_q == OWN_NONE) ||
                  (!lock_i && (done_i || phase_q == OWN_DRAIN));

  always_comb begin
    phase_d = phase_q;
    if (free_o) begin
      phase_d = regrant_i ? OWN_XFER : OWN_NONE;
    end else if (phase_q == OWN_XFER && done_i) begin
      phase_d = OWN_DRAIN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= OWN_NONE;
    else         phase_q <= phase_d;
  end

endmodule

// File: rtl/arb_sleep_wake.sv
module arb_sleep_wake #(
  parameter int unsigned N_MST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic [N_MST-1:0] gnt_q_i,
  input  logic [N_MST-1:0] gnt_d_i,
  output logic [N_MST-1:0] sleep_o,
  output logic [N_MST-1:0] wake_o
);

  logic [N_MST-1:0] sleep_q, sleep_d;
  logic [N_MST-1:0] wake_q, wake_d;
  logic             owned_d;

  assign owned_d = |gnt_d_i;

  for (genvar i = 0; i < N_MST; i++) begin : g_mst
    assign sleep_d[i] = req_i[i] & owned_d & ~gnt_d_i[i];
    // wake only a sleeper that is handed the bus
    assign wake_d[i]  = sleep_q[i] & req_i[i] & gnt_d_i[i] & ~gnt_q_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= '0;
      wake_q  <= '0;
    end else begin
      sleep_q <= sleep_d;
      wake_q  <= wake_d;
    end
  end

  // withdrawal clears sleep without waiting for an edge
  assign sleep_o = sleep_q & req_i;
  assign wake_o  = wake_q;

endmodule

// File: rtl/bus_sleep_arbiter.sv
module bus_sleep_arbiter #(
  parameter int unsigned N_MST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             lock_i,
  input  logic             done_i,
  output logic [N_MST-1:0] gnt_o,
  output logic [N_MST-1:0] sleep_o,
  output logic [N_MST-1:0] wake_o
);

  logic [N_MST-1:0] gnt_q, gnt_d, pick;
  logic             free;

  arb_prio_pick #(.N_MST(N_MST)) u_pick (
    .req_i  (req_i),
    .pick_o (pick)
  );

  arb_hold_ctrl u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (lock_i),
    .done_i    (done_i),
    .regrant_i (|pick),
    .free_o    (free)
  );

  assign gnt_d = free ? pick : gnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  arb_sleep_wake #(.N_MST(N_MST)) u_sw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .gnt_q_i (gnt_q),
    .gnt_d_i (gnt_d),
    .sleep_o (sleep_o),
    .wake_o  (wake_o)
  );

  assign gnt_o = gnt_q;

endmodule

// File: rtl/bus_sleep_arbiter_chk.sv
module bus_sleep_arbiter_chk #(
  parameter int unsigned N_MST = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic             lock_i,
  input logic             done_i,
  input logic [N_MST-1:0] gnt_o,
  input logic [N_MST-1:0] sleep_o,
  input logic [N_MST-1:0] wake_o
);

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_new_gnt_requested_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && gnt_o != $past(gnt_o)) |-> (($past(req_i) & gnt_o) != '0));

  assert_lock_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && lock_i) |=> (gnt_o == $past(gnt_o)));

  assert_xfer_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && gnt_o != $past(gnt_o) && !done_i) |=> (gnt_o == $past(gnt_o)));

  for (genvar i = 0; i < N_MST; i++) begin : g_mst
    assert_sleep_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_o[i] |-> (req_i[i] && gnt_o != '0 && !gnt_o[i]));

    assert_wake_on_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o[i] |-> (gnt_o[i] && $past(sleep_o[i]) && !$past(gnt_o[i])));

    assert_wake_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o[i] |=> !wake_o[i]);
  end

endmodule

bind bus_sleep_arbiter bus_sleep_arbiter_chk #(.N_MST(N_MST)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .lock_i  (lock_i),
  .done_i  (done_i),
  .gnt_o   (gnt_o),
  .sleep_o (sleep_o),
  .wake_o  (wake_o)
);

// File: tb/bus_sleep_arbiter_tb.sv
module bus_sleep_arbiter_tb;

  localparam int unsigned N_MST = 2;
  localparam int unsigned N_VEC = 19;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_MST-1:0] req_i = '0;
  logic             lock_i = 1'b0;
  logic             done_i = 1'b0;
  logic [N_MST-1:0] gnt_o, sleep_o, wake_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  bus_sleep_arbiter #(.N_MST(N_MST)) u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .lock_i  (lock_i),
    .done_i  (done_i),
    .gnt_o   (gnt_o),
    .sleep_o (sleep_o),
    .wake_o  (wake_o)
  );

  // {req, lock, done, exp_gnt, exp_sleep, exp_wake}; bit0 = master 0
  localparam logic [9:0] VEC [N_VEC] = '{
    {2'b00, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00},  // 0  R9 idle
    {2'b00, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00},  // 1  R9 done without owner
    {2'b11, 1'b0, 1'b0, 2'b01, 2'b10, 2'b00},  // 2  R2 both request
    {2'b11, 1'b0, 1'b0, 2'b01, 2'b10, 2'b00},  // 3  R4 transfer running
    {2'b11, 1'b1, 1'b1, 2'b01, 2'b10, 2'b00},  // 4  R3 done under lock
    {2'b11, 1'b1, 1'b0, 2'b01, 2'b10, 2'b00},  // 5  R3 lock held
    {2'b10, 1'b0, 1'b0, 2'b10, 2'b00, 2'b10},  // 6  R7 lock drop, wake m1
    {2'b10, 1'b0, 1'b0, 2'b10, 2'b00, 2'b00},  // 7  R8 pulse ends
    {2'b11, 1'b0, 1'b0, 2'b10, 2'b01, 2'b00},  // 8  R5 m0 refused
    {2'b10, 1'b0, 1'b0, 2'b10, 2'b00, 2'b00},  // 9  R6 m0 withdraws
    {2'b11, 1'b0, 1'b0, 2'b10, 2'b01, 2'b00},  // 10 R5 m0 refused again
    {2'b11, 1'b0, 1'b1, 2'b01, 2'b10, 2'b01},  // 11 R7 release, wake m0
    {2'b11, 1'b0, 1'b1, 2'b01, 2'b10, 2'b00},  // 12 R10 owner keeps bus
    {2'b01, 1'b0, 1'b1, 2'b01, 2'b00, 2'b00},  // 13 R2 regrant m0 alone
    {2'b00, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00},  // 14 R9 release, nobody
    {2'b10, 1'b0, 1'b0, 2'b10, 2'b00, 2'b00},  // 15 R2 m1 alone
    {2'b11, 1'b0, 1'b0, 2'b10, 2'b01, 2'b00},  // 16 R5
    {2'b11, 1'b0, 1'b1, 2'b01, 2'b10, 2'b01},  // 17 R7
    {2'b11, 1'b0, 1'b0, 2'b01, 2'b10, 2'b00}   // 18 R8
  };

  function automatic string tag_of(int idx);
    case (idx)
      0, 1, 14:      return "R9";
      2, 13, 15:     return "R2";
      3:             return "R4";
      4, 5:          return "R3";
      6, 11, 17:     return "R7";
      7, 18:         return "R8";
      8, 10, 16:     return "R5";
      9:             return "R6";
      default:       return "R10";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [N_MST-1:0] act, logic [N_MST-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    #5;
    check("R1", "gnt in reset", gnt_o, '0);
    check("R1", "sleep in reset", sleep_o, '0);
    check("R1", "wake in reset", wake_o, '0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < N_VEC; v++) begin
      @(negedge clk_i);
      {req_i, lock_i, done_i} = VEC[v][9:6];
      @(posedge clk_i);
      #5;
      check(tag_of(v), $sformatf("vec%0d gnt", v), gnt_o, VEC[v][5:4]);
      check(tag_of(v), $sformatf("vec%0d sleep", v), sleep_o, VEC[v][3:2]);
      check(tag_of(v), $sformatf("vec%0d wake", v), wake_o, VEC[v][1:0]);
    end

    // R6: m1 asleep behind m0; withdrawal clears sleep before any edge
    @(negedge clk_i);
    req_i  = 2'b01;
    done_i = 1'b0;
    #1;
    check("R6", "sleep same cycle", sleep_o, 2'b00);
    check("R6", "gnt unchanged", gnt_o, 2'b01);

    // R3: lock with no transfer done keeps the bus for several cycles
    lock_i = 1'b1;
    req_i  = 2'b11;
    repeat (3) @(posedge clk_i);
    #5;
    check("R3", "long lock gnt", gnt_o, 2'b01);
    check("R5", "long lock sleep", sleep_o, 2'b10);

    // R1: asynchronous reset in mid ownership
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", "async gnt", gnt_o, '0);
    check("R1", "async sleep", sleep_o, '0);
    check("R1", "async wake", wake_o, '0);

    // R9: lock and done with no owner change nothing
    @(negedge clk_i);
    req_i  = 2'b00;
    lock_i = 1'b1;
    done_i = 1'b1;
    rst_ni = 1'b1;
    @(posedge clk_i);
    #5;
    check("R9", "no owner gnt", gnt_o, '0);
    // then a request is granted despite lock from nobody
    @(negedge clk_i);
    lock_i = 1'b0;
    done_i = 1'b0;
    req_i  = 2'b10;
    @(posedge clk_i);
    #5;
    check("R2", "grant after reset", gnt_o, 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule